// File: doc/BRIEF.md
# Two-Part Packet Reassembly Buffer with Cut-Through

This stage sits between a network port and a processing pipeline. Each 88-bit packet arrives as two flits on consecutive accepted transfers. The first flit is 48 bits wide and carries an 8-bit destination address and a 40-bit tag. The second flit carries a 40-bit body that holds the data type and the value. The stage joins the two flits and presents the packet with its three fields separated on a single output port.

When nothing is queued and the consumer is ready, the packet completed by an arriving second flit appears on the output in the same cycle and is not stored. Otherwise the packet is written into a buffer memory of 40-bit words, three words per packet: the padded address, the tag and the body. Queued packets leave in arrival order.

A second flit that arrives without a first flit before it is dropped, and a sticky error flag is raised. The input accepts flits only while the memory still has room for a whole packet.

Top module: `flit_packet_buffer`

## Requirements
- R1: An input flit with `in_tail`=0 is a first flit: bits [47:40] are the address and bits [39:0] are the tag. A flit with `in_tail`=1 is a second flit, and its bits [39:0] are the body. The completed packet is output with `out_addr`, `out_tag` and `out_data` equal to those fields.
- R2: When the queue is empty, `out_ready` is 1 and an accepted second flit completes a packet, `out_valid` is 1 in that same cycle with that packet, and nothing is stored.
- R3: A completed packet that is not delivered in its own cycle is stored. It is presented on the output from the next cycle on.
- R4: Packets are delivered in the order they were completed. The cut-through path is never used while an older packet is queued.
- R5: `in_ready` is 1 exactly when at least three free words, that is one packet slot, remain in the memory. The default is 24 words, or 8 packets. A flit offered while `in_ready` is 0 is not taken.
- R6: An accepted second flit with no pending first flit produces no packet and sets `proto_err`, which then stays 1 until reset.
- R7: A first flit accepted while an earlier first flit is still pending replaces it. The next second flit completes a packet with the newer address and tag.
- R8: During reset `in_ready` is 1, `out_valid` is 0 and `proto_err` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output stays valid and its fields stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted when high together with in_valid |
| in_tail | input | 1 | 0 = first flit (address and tag), 1 = second flit (body) |
| in_flit | input | 48 | Flit payload |
| out_valid | output | 1 | Packet available |
| out_ready | input | 1 | Consumer takes the packet |
| out_addr | output | 8 | Packet address |
| out_tag | output | 40 | Packet tag |
| out_data | output | 40 | Packet body (data type and value) |
| proto_err | output | 1 | Sticky flag for an orphan second flit |

## Verification
The bench builds the block with the default 24-word memory, which gives eight packet slots. At this size a short run with the consumer stalled fills every slot, drops `in_ready` and then wraps the slot pointers while the queue drains. Random backpressure and random flit ordering against a packet-level model exercise the cut-through decision on every cycle, including the cycle when the last queued packet leaves. Directed phases cover the replaced first flit and the orphan second flit.

// File: rtl/flitbuf_pkg.sv
package flitbuf_pkg;
  localparam int ADDR_W        = 8;
  localparam int TAG_W         = 40;
  localparam int BODY_W        = 40;
  localparam int HEAD_W        = ADDR_W + TAG_W;
  localparam int PKT_W         = HEAD_W + BODY_W;
  localparam int WORD_W        = 40;
  localparam int WORDS_PER_PKT = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
    logic [BODY_W-1:0] body;
  } pkt_t;
endpackage

// File: rtl/flit_joiner.sv
module flit_joiner
  import flitbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              is_tail,
  input  logic [HEAD_W-1:0] flit,
  output logic              pkt_done,
  output pkt_t              pkt,
  output logic              err
);
  logic              hold_q, hold_d;
  logic              err_q, err_d;
  logic [HEAD_W-1:0] held_q;
  logic              load_head;

  assign load_head = take && !is_tail;

  always_comb begin
    hold_d = hold_q;
    err_d  = err_q;
    if (take) begin
      if (!is_tail) begin
        hold_d = 1'b1;
      end else begin
        hold_d = 1'b0;
        if (!hold_q) err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_head) held_q <= flit;
  end

  assign pkt_done = take && is_tail && hold_q;
  assign pkt      = {held_q, flit[BODY_W-1:0]};
  assign err      = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R6
endmodule

// File: rtl/pkt_word_store.sv
module pkt_word_store
  import flitbuf_pkg::*;
#(
  parameter int DEPTH_WORDS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  pkt_t wr_pkt,
  input  logic pop,
  output pkt_t rd_pkt,
  output logic empty,
  output logic has_room
);
  localparam int SLOTS = DEPTH_WORDS / WORDS_PER_PKT;
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int ADR_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(SLOTS - 1);

  logic [WORD_W-1:0] mem [DEPTH_WORDS];
  logic [WORD_W-1:0] wr_words [WORDS_PER_PKT];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADR_W-1:0]  wr_base, rd_base;

  assign wr_words[0] = {{(WORD_W-ADDR_W){1'b0}}, wr_pkt.addr};
  assign wr_words[1] = wr_pkt.tag;
  assign wr_words[2] = wr_pkt.body;

  assign wr_base = ADR_W'(int'(wr_ptr_q) * WORDS_PER_PKT);
  assign rd_base = ADR_W'(int'(rd_ptr_q) * WORDS_PER_PKT);

  always_ff @(posedge clk) begin
    if (push) begin
      for (int k = 0; k < WORDS_PER_PKT; k++) begin
        mem[wr_base + ADR_W'(k)] <= wr_words[k];
      end
    end
  end

  assign rd_pkt.addr = mem[rd_base][ADDR_W-1:0];
  assign rd_pkt.tag  = mem[rd_base + ADR_W'(1)];
  assign rd_pkt.body = mem[rd_base + ADR_W'(2)];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST_P) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + PTR_W'(1);
    if (push && !pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign empty    = (cnt_q == '0);
  assign has_room = (cnt_q < SLOTS_C);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != SLOTS_C) || pop); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/flit_packet_buffer.sv
module flit_packet_buffer
  import flitbuf_pkg::*;
#(
  parameter int DEPTH_WORDS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tail,
  input  logic [HEAD_W-1:0] in_flit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [TAG_W-1:0]  out_tag,
  output logic [BODY_W-1:0] out_data,
  output logic              proto_err
);
  logic take, asm_done, st_empty, st_room, bypass, push, pop;
  pkt_t asm_pkt, st_pkt, sel_pkt;

  assign in_ready = st_room;
  assign take     = in_valid && st_room;

  flit_joiner u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .is_tail  (in_tail),
    .flit     (in_flit),
    .pkt_done (asm_done),
    .pkt      (asm_pkt),
    .err      (proto_err)
  );

  assign bypass = asm_done && st_empty && out_ready;
  assign push   = asm_done && !bypass;
  assign pop    = !st_empty && out_ready;

  pkt_word_store #(.DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .wr_pkt   (asm_pkt),
    .pop      (pop),
    .rd_pkt   (st_pkt),
    .empty    (st_empty),
    .has_room (st_room)
  );

  assign out_valid = !st_empty || asm_done;
  assign sel_pkt   = st_empty ? asm_pkt : st_pkt;
  assign out_addr  = sel_pkt.addr;
  assign out_tag   = sel_pkt.tag;
  assign out_data  = sel_pkt.body;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_addr, out_tag, out_data}))); // R9
endmodule

// File: tb/sim_flit_packet_buffer.sv
module sim_flit_packet_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_tail;
  logic [47:0] in_flit;
  logic        out_valid, out_ready;
  logic [7:0]  out_addr;
  logic [39:0] out_tag, out_data;
  logic        proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [87:0] mq [0:15];
  int          mqn = 0;
  bit          pend = 1'b0;
  logic [47:0] ph = '0;
  bit          merr = 1'b0;
  string       lbl = "R1";

  always #5 clk = ~clk;

  flit_packet_buffer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tail(in_tail), .in_flit(in_flit), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_tag(out_tag),
    .out_data(out_data), .proto_err(proto_err)
  );

  task automatic chk(string req, logic [87:0] act, logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [87:0] join_pkt(logic [47:0] h, logic [47:0] t);
    return {h, t[39:0]};
  endfunction

  // Called right after a falling edge with inputs set; returns at the next falling edge.
  task automatic tick();
    bit          exp_rdy, fire, comp, exp_ov;
    logic [87:0] newp, expp;
    #2;
    exp_rdy = (mqn < 8);
    chk("R5", {87'd0, in_ready}, {87'd0, exp_rdy});
    chk("R6", {87'd0, proto_err}, {87'd0, merr});
    fire   = in_valid && exp_rdy;
    comp   = fire && in_tail && pend;
    newp   = join_pkt(ph, in_flit);
    exp_ov = (mqn > 0) || comp;
    chk((mqn == 0 && comp) ? "R2" : "R3", {87'd0, out_valid}, {87'd0, exp_ov});
    if (exp_ov) begin
      expp = (mqn > 0) ? mq[0] : newp;
      chk(lbl, {out_addr, out_tag, out_data}, expp);
    end
    @(posedge clk);
    if (exp_ov && out_ready) begin
      if (mqn > 0) begin
        for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
        mqn--;
        if (comp) begin mq[mqn] = newp; mqn++; end
      end
    end else if (comp) begin
      mq[mqn] = newp; mqn++;
    end
    if (fire) begin
      if (!in_tail) begin pend = 1'b1; ph = in_flit; end
      else begin
        if (!pend) merr = 1'b1;
        pend = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic put(bit tail, logic [47:0] f, bit ordy);
    in_valid = 1'b1; in_tail = tail; in_flit = f; out_ready = ordy;
    tick();
  endtask

  task automatic idle(bit ordy, int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_tail = 1'b0; in_flit = '0; out_ready = ordy;
      tick();
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [87:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_tail = 1'b0; in_flit = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R8", {85'd0, in_ready, out_valid, proto_err}, {85'd0, 3'b100});
    @(negedge clk);
    rst_n = 1'b1;

    // Cut-through with an empty queue
    lbl = "R2";
    put(1'b0, {8'hA5, 40'h11_2233_4455}, 1'b1);
    put(1'b1, {8'h00, 40'hAB_CDEF_0123}, 1'b1);
    idle(1'b1, 2);

    // Stall, then the stored packet is presented
    lbl = "R3";
    put(1'b0, {8'h3C, 40'h00_0000_0001}, 1'b0);
    put(1'b1, {8'h00, 40'hFF_FFFF_FFFF}, 1'b0);
    put(1'b0, {8'h7E, 40'h00_0000_0002}, 1'b0);
    put(1'b1, {8'h00, 40'h55_5555_5555}, 1'b0);
    held = {out_addr, out_tag, out_data};
    in_valid = 1'b0; out_ready = 1'b0; tick();
    chk("R9", {out_addr, out_tag, out_data}, held);
    chk("R9", {87'd0, out_valid}, 88'd1);
    lbl = "R4";
    idle(1'b1, 4);

    // Fill every slot with the consumer stalled
    lbl = "R5";
    for (int i = 0; i < 22; i++)
      put(i[0], {i[7:0], 32'h0, i[7:0]}, 1'b0);
    idle(1'b0, 2);
    lbl = "R4";
    idle(1'b1, 12);

    // A newer first flit replaces the pending one
    lbl = "R7";
    put(1'b0, {8'h11, 40'h11_1111_1111}, 1'b1);
    put(1'b0, {8'h22, 40'h22_2222_2222}, 1'b1);
    put(1'b1, {8'h00, 40'h33_3333_3333}, 1'b1);
    idle(1'b1, 2);

    // Orphan second flit
    lbl = "R6";
    put(1'b1, {8'h00, 40'hDE_ADBE_EF00}, 1'b1);
    idle(1'b1, 2);

    // Random traffic with backpressure
    lbl = "R4";
    for (int i = 0; i < 4000; i++) begin
      bit v, t, r;
      v = ($urandom % 4) != 0;
      t = (($urandom % 20) == 0) ? !pend : pend;
      r = ($urandom % 3) != 0;
      if (i > 1500 && i < 2000) r = ($urandom % 6) == 0;
      in_valid = v; in_tail = t; out_ready = r;
      in_flit = {$urandom, $urandom}[47:0];
      tick();
    end
    idle(1'b1, 12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule